// File: doc/BRIEF.md
# Sub-word Load/Store Lane Unit

This block sits between a 32-bit datapath and a word-organised data memory and handles memory accesses narrower than a word. It forms the effective address from a base register and a signed 16-bit displacement. On stores it steers the low byte or low halfword of the source operand onto every lane of the memory write bus and raises only the byte-enables that belong to the addressed location. On loads it picks the addressed byte or halfword out of the word returned by memory and widens it to 32 bits, with sign or zero fill depending on the operation.

The unit is registered. A request presented in one cycle produces the address, write data, byte-enables and misalignment flag one clock later. The memory is expected to return read data for that address in the next cycle, and the widened load result appears on the clock after that. A halfword access at an odd address is flagged and touches no byte.

Operation codes on `op_i`: 0 none, 1 signed byte load, 2 unsigned byte load, 3 signed halfword load, 4 unsigned halfword load, 5 word load, 6 byte store, 7 halfword store, 8 word store. Codes 9 to 15 are treated as no operation.

Top module: `sublane_lsu`

## Requirements
- R1: While `rst_n` is low, every output is zero.
- R2: One cycle after a request, `mem_addr_o` equals `base_i` plus `offset_i` sign-extended to 32 bits, modulo 2^32. This holds for every operation code.
- R3: A signed byte load (1) or signed halfword load (3) returns the selected value sign-extended to 32 bits.
- R4: An unsigned byte load (2) or unsigned halfword load (4) returns the selected value zero-extended to 32 bits.
- R5: Lanes are little-endian. Address bits [1:0] = k select byte k, which is bits [8k+7:8k] of the memory word. For halfwords, address bit 1 = h selects bits [16h+15:16h].
- R6: A byte store (6) raises exactly the byte-enable bit k, where k is address bits [1:0]. It drives the source bits [7:0] on all four byte lanes of `mem_wdata_o`.
- R7: An aligned halfword store (7) raises enables 4'b0011 when address bit 1 is 0 and 4'b1100 when it is 1. It drives the source bits [15:0] on both halfword lanes.
- R8: A halfword load or store whose address has bit 0 set asserts `misalign_o` and drives `mem_be_o` to zero. A misaligned halfword load returns zero as its result.
- R9: A word store (8) drives the source unchanged with enables 4'b1111. A word load (5) returns the memory word unchanged.
- R10: A load result appears on `load_o` two cycles after the load request. With no load two cycles earlier, `load_o` holds its value. Loads never raise a byte-enable and drive `mem_wdata_o` to zero.
- R11: Code 0 and codes 9 to 15 raise no enable, no misalignment flag and drive zero write data. They do not disturb `load_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Operation code |
| base_i | input | 32 | Base register value |
| offset_i | input | 16 | Signed displacement |
| store_i | input | 32 | Store source register |
| mem_rdata_i | input | 32 | Memory read word, valid the cycle after the address |
| mem_addr_o | output | 32 | Effective byte address |
| mem_wdata_o | output | 32 | Lane-steered write data |
| mem_be_o | output | 4 | Byte write enables |
| load_o | output | 32 | Extended load result |
| misalign_o | output | 1 | Odd-address halfword access |

## Verification
The assertions assume that the memory presents the read word for `mem_addr_o` exactly one cycle after the address, and that `op_i` is sampled as a plain code every cycle with no separate valid strobe. The stimulus meets this because the bench drives a fresh `mem_rdata_i` every cycle and its model always pairs the read word of cycle n+1 with the request of cycle n. The stimulus walks every lane offset and every code, including the undefined ones. It uses read words whose selected bytes have the top bit set and clear, and displacements that are negative or wrap the address space.

// File: rtl/sublane_pkg.sv
package sublane_pkg;

    localparam logic [3:0] OP_NONE = 4'd0;
    localparam logic [3:0] OP_LDB  = 4'd1;
    localparam logic [3:0] OP_LDBU = 4'd2;
    localparam logic [3:0] OP_LDH  = 4'd3;
    localparam logic [3:0] OP_LDHU = 4'd4;
    localparam logic [3:0] OP_LDW  = 4'd5;
    localparam logic [3:0] OP_STB  = 4'd6;
    localparam logic [3:0] OP_STH  = 4'd7;
    localparam logic [3:0] OP_STW  = 4'd8;

    typedef enum logic [1:0] {SZ_NONE, SZ_B, SZ_H, SZ_W} size_e;

    typedef struct packed {
        size_e size;
        logic  store;
        logic  load;
        logic  sgn;
    } dec_t;

    function automatic dec_t decode(input logic [3:0] op);
        dec_t d;
        d = '{size: SZ_NONE, store: 1'b0, load: 1'b0, sgn: 1'b0};
        case (op)
            OP_LDB:  d = '{size: SZ_B, store: 1'b0, load: 1'b1, sgn: 1'b1};
            OP_LDBU: d = '{size: SZ_B, store: 1'b0, load: 1'b1, sgn: 1'b0};
            OP_LDH:  d = '{size: SZ_H, store: 1'b0, load: 1'b1, sgn: 1'b1};
            OP_LDHU: d = '{size: SZ_H, store: 1'b0, load: 1'b1, sgn: 1'b0};
            OP_LDW:  d = '{size: SZ_W, store: 1'b0, load: 1'b1, sgn: 1'b0};
            OP_STB:  d = '{size: SZ_B, store: 1'b1, load: 1'b0, sgn: 1'b0};
            OP_STH:  d = '{size: SZ_H, store: 1'b1, load: 1'b0, sgn: 1'b0};
            OP_STW:  d = '{size: SZ_W, store: 1'b1, load: 1'b0, sgn: 1'b0};
            default: d = '{size: SZ_NONE, store: 1'b0, load: 1'b0, sgn: 1'b0};
        endcase
        return d;
    endfunction

endpackage

// File: rtl/sublane_agen.sv
module sublane_agen #(
    parameter int XLEN = 32,
    parameter int OFFW = 16
) (
    input  logic [XLEN-1:0] base_i,
    input  logic [OFFW-1:0] offset_i,
    output logic [XLEN-1:0] ea_o
);
    localparam int EXTW = XLEN - OFFW;

    logic [XLEN-1:0] disp;

    always_comb begin
        disp = {{EXTW{offset_i[OFFW-1]}}, offset_i};
        ea_o = base_i + disp;
    end
endmodule

// File: rtl/sublane_steer.sv
module sublane_steer
    import sublane_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  size_e                   size_i,
    input  logic                    store_i,
    input  logic [$clog2(XLEN/8)-1:0] lo_i,
    input  logic [XLEN-1:0]         data_i,
    output logic [XLEN-1:0]         wdata_o,
    output logic [XLEN/8-1:0]       be_o,
    output logic                    mis_o
);
    localparam int NLANE = XLEN / 8;
    localparam int LB    = $clog2(NLANE);

    assign mis_o = (size_i == SZ_H) && lo_i[0];

    for (genvar l = 0; l < NLANE; l++) begin : g_lane
        logic hit;
        logic [7:0] lane_d;

        always_comb begin
            case (size_i)
                SZ_B:    hit = (int'(lo_i) == l);
                SZ_H:    hit = (int'(lo_i[LB-1:1]) == (l / 2)) && !lo_i[0];
                SZ_W:    hit = 1'b1;
                default: hit = 1'b0;
            endcase
        end

        always_comb begin
            case (size_i)
                SZ_B:    lane_d = data_i[7:0];
                SZ_H:    lane_d = data_i[(l % 2) * 8 +: 8];
                SZ_W:    lane_d = data_i[l * 8 +: 8];
                default: lane_d = 8'h00;
            endcase
        end

        assign be_o[l]           = store_i && hit;
        assign wdata_o[l*8 +: 8] = store_i ? lane_d : 8'h00;
    end
endmodule

// File: rtl/sublane_extract.sv
module sublane_extract
    import sublane_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0]           rdata_i,
    input  size_e                     size_i,
    input  logic                      sgn_i,
    input  logic [$clog2(XLEN/8)-1:0] sel_i,
    input  logic                      mis_i,
    output logic [XLEN-1:0]           result_o
);
    localparam int NLANE = XLEN / 8;
    localparam int LB    = $clog2(NLANE);

    logic [7:0]  byte_v;
    logic [15:0] half_v;

    always_comb begin
        byte_v = rdata_i[8 * int'(sel_i) +: 8];
        half_v = rdata_i[16 * int'(sel_i[LB-1:1]) +: 16];
        case (size_i)
            SZ_B:    result_o = {{(XLEN-8){sgn_i & byte_v[7]}}, byte_v};
            SZ_H:    result_o = {{(XLEN-16){sgn_i & half_v[15]}}, half_v};
            SZ_W:    result_o = rdata_i;
            default: result_o = '0;
        endcase
        if (mis_i) begin
            result_o = '0;
        end
    end
endmodule

// File: rtl/sublane_lsu.sv
module sublane_lsu
    import sublane_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int OFFW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        op_i,
    input  logic [XLEN-1:0]   base_i,
    input  logic [OFFW-1:0]   offset_i,
    input  logic [XLEN-1:0]   store_i,
    input  logic [XLEN-1:0]   mem_rdata_i,
    output logic [XLEN-1:0]   mem_addr_o,
    output logic [XLEN-1:0]   mem_wdata_o,
    output logic [XLEN/8-1:0] mem_be_o,
    output logic [XLEN-1:0]   load_o,
    output logic              misalign_o
);
    localparam int NLANE = XLEN / 8;
    localparam int LB    = $clog2(NLANE);

    typedef struct packed {
        logic [XLEN-1:0]  addr;
        logic [XLEN-1:0]  wdata;
        logic [NLANE-1:0] be;
        logic             mis;
        logic             ld_pend;
        size_e            ld_size;
        logic             ld_sgn;
        logic [LB-1:0]    ld_sel;
        logic [XLEN-1:0]  load;
    } stage_t;

    stage_t s_d, s_q;
    dec_t   dec;

    logic [XLEN-1:0]  ea;
    logic [XLEN-1:0]  wd_c;
    logic [NLANE-1:0] be_c;
    logic             mis_c;
    logic [XLEN-1:0]  ld_c;

    assign dec = decode(op_i);

    sublane_agen #(.XLEN(XLEN), .OFFW(OFFW)) u_agen (
        .base_i   (base_i),
        .offset_i (offset_i),
        .ea_o     (ea)
    );

    sublane_steer #(.XLEN(XLEN)) u_steer (
        .size_i  (dec.size),
        .store_i (dec.store),
        .lo_i    (ea[LB-1:0]),
        .data_i  (store_i),
        .wdata_o (wd_c),
        .be_o    (be_c),
        .mis_o   (mis_c)
    );

    sublane_extract #(.XLEN(XLEN)) u_extract (
        .rdata_i  (mem_rdata_i),
        .size_i   (s_q.ld_size),
        .sgn_i    (s_q.ld_sgn),
        .sel_i    (s_q.ld_sel),
        .mis_i    (s_q.mis),
        .result_o (ld_c)
    );

    always_comb begin
        s_d         = s_q;
        s_d.addr    = ea;
        s_d.wdata   = wd_c;
        s_d.be      = be_c;
        s_d.mis     = mis_c;
        s_d.ld_pend = dec.load;
        s_d.ld_size = dec.size;
        s_d.ld_sgn  = dec.sgn;
        s_d.ld_sel  = ea[LB-1:0];
        if (s_q.ld_pend) begin
            s_d.load = ld_c;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign mem_addr_o  = s_q.addr;
    assign mem_wdata_o = s_q.wdata;
    assign mem_be_o    = s_q.be;
    assign misalign_o  = s_q.mis;
    assign load_o      = s_q.load;
endmodule

// File: rtl/sublane_chk.sv
module sublane_chk
    import sublane_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int OFFW = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        op_i,
    input logic [XLEN-1:0]   base_i,
    input logic [OFFW-1:0]   offset_i,
    input logic [XLEN-1:0]   store_i,
    input logic [XLEN-1:0]   mem_addr_o,
    input logic [XLEN-1:0]   mem_wdata_o,
    input logic [XLEN/8-1:0] mem_be_o,
    input logic [XLEN-1:0]   load_o,
    input logic              misalign_o
);
    localparam int NLANE = XLEN / 8;

    logic [XLEN-1:0] sum_w;
    logic            is_ld;
    logic            armed;
    logic            ld_c1;
    logic            ld_c2;

    assign sum_w = base_i + {{(XLEN-OFFW){offset_i[OFFW-1]}}, offset_i};
    assign is_ld = (op_i >= OP_LDB) && (op_i <= OP_LDW);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed <= 1'b0;
            ld_c1 <= 1'b0;
            ld_c2 <= 1'b0;
        end else begin
            armed <= 1'b1;
            ld_c1 <= is_ld;
            ld_c2 <= ld_c1;
        end
    end

    // R8
    misalign_no_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        misalign_o |-> (mem_be_o == '0));

    // R6
    enable_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(mem_be_o) == 0) || ($countones(mem_be_o) == 1) ||
        ($countones(mem_be_o) == 2) || ($countones(mem_be_o) == NLANE));

    // R2
    addr_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (mem_addr_o == $past(sum_w)));

    // R9
    word_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && ($past(op_i) == OP_STW)) |-> ((mem_be_o == '1) && (mem_wdata_o == $past(store_i))));

    // R10
    load_no_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(is_ld)) |-> ((mem_be_o == '0) && (mem_wdata_o == '0)));

    // R10
    load_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_c2 |-> $stable(load_o));
endmodule

bind sublane_lsu sublane_chk #(.XLEN(XLEN), .OFFW(OFFW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_i        (op_i),
    .base_i      (base_i),
    .offset_i    (offset_i),
    .store_i     (store_i),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_be_o    (mem_be_o),
    .load_o      (load_o),
    .misalign_o  (misalign_o)
);

// File: tb/sim_sublane_lsu.sv
module sim_sublane_lsu;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op = 4'd0;
    logic [31:0] base = 32'd0;
    logic [15:0] off = 16'd0;
    logic [31:0] st = 32'd0;
    logic [31:0] rd = 32'd0;
    logic [31:0] mem_addr, mem_wdata, load_v;
    logic [3:0]  mem_be;
    logic        mis;

    int n_chk = 0;
    int n_bad = 0;

    // reference model state
    logic [31:0] m_addr = 0, m_wd = 0, m_ld = 0, p_ea = 0;
    logic [3:0]  m_be = 0;
    logic        m_mis = 0;
    int          p_op = 0;
    string       t_st = "R1", t_ld = "R1";

    sublane_lsu u0 (
        .clk(clk), .rst_n(rst_n), .op_i(op), .base_i(base), .offset_i(off),
        .store_i(st), .mem_rdata_i(rd), .mem_addr_o(mem_addr),
        .mem_wdata_o(mem_wdata), .mem_be_o(mem_be), .load_o(load_v),
        .misalign_o(mis)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
        end
    endtask

    function automatic logic [31:0] ref_load(input int o, input logic [31:0] ea,
                                             input logic [31:0] w);
        longint v;
        case (o)
            1, 2: begin
                v = (longint'(w) >> (8 * int'(ea[1:0]))) & 255;
                if (o == 1 && v >= 128) v = v - 256;
                return 32'(v);
            end
            3, 4: begin
                if (ea[0]) return 32'd0;
                v = (longint'(w) >> (16 * int'(ea[1]))) & 65535;
                if (o == 3 && v >= 32768) v = v - 65536;
                return 32'(v);
            end
            5: return w;
            default: return 32'd0;
        endcase
    endfunction

    function automatic string ld_tag(input int o, input logic [31:0] ea);
        case (o)
            1, 3: return ((o == 3) && ea[0]) ? "R8" : "R3 R5";
            2, 4: return ((o == 4) && ea[0]) ? "R8" : "R4 R5";
            5: return "R9";
            default: return "R10";
        endcase
    endfunction

    // behavioural model, advanced on every rising edge
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_addr = 0; m_wd = 0; m_ld = 0; m_be = 0; m_mis = 0; p_op = 0; p_ea = 0;
        end else begin
            longint offs;
            logic [31:0] ea;
            if (p_op >= 1 && p_op <= 5) begin
                m_ld = ref_load(p_op, p_ea, rd);
                t_ld = ld_tag(p_op, p_ea);
            end else begin
                t_ld = "R10";
            end
            offs = (off >= 16'h8000) ? longint'(off) - 65536 : longint'(off);
            ea = 32'(longint'(base) + offs);
            m_addr = ea;
            m_wd = 0; m_be = 0; m_mis = 0;
            case (int'(op))
                6: begin
                    m_wd = {4{st[7:0]}}; m_be = 4'(1 << ea[1:0]); t_st = "R6 R5";
                end
                7: begin
                    m_wd = {2{st[15:0]}};
                    if (ea[0]) begin m_mis = 1; t_st = "R8"; end
                    else begin m_be = ea[1] ? 4'b1100 : 4'b0011; t_st = "R7 R5"; end
                end
                8: begin m_wd = st; m_be = 4'hF; t_st = "R9"; end
                1, 2, 3, 4, 5: begin
                    m_mis = (op == 3 || op == 4) && ea[0];
                    t_st = m_mis ? "R8" : "R10";
                end
                default: t_st = "R11";
            endcase
            if (op != 7 || !ea[0]) begin
                if (op == 7) m_wd = {2{st[15:0]}};
            end
            if (op == 7 && ea[0]) m_wd = {2{st[15:0]}};
            p_op = int'(op);
            p_ea = ea;
        end
    end

    // compare on every falling edge once out of reset
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R2", "addr", mem_addr, m_addr);
            chk(t_st, "wdata", mem_wdata, m_wd);
            chk(t_st, "be", {28'd0, mem_be}, {28'd0, m_be});
            chk(t_st, "misalign", {31'd0, mis}, {31'd0, m_mis});
            chk(t_ld, "load", load_v, m_ld);
        end
    end

    task automatic drive(input logic [3:0] o, input logic [31:0] b, input logic [15:0] d,
                         input logic [31:0] s, input logic [31:0] r);
        @(negedge clk);
        op = o; base = b; off = d; st = s; rd = r;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "addr", mem_addr, 32'd0);
        chk("R1", "wdata", mem_wdata, 32'd0);
        chk("R1", "be", {28'd0, mem_be}, 32'd0);
        chk("R1", "misalign", {31'd0, mis}, 32'd0);
        chk("R1", "load", load_v, 32'd0);
        rst_n = 1'b1;

        // R3 R4 R5: every load type at every lane, two read patterns
        for (int p = 0; p < 2; p++) begin
            for (int o = 1; o <= 5; o++) begin
                for (int k = 0; k < 4; k++) begin
                    drive(4'(o), 32'h0000_1000, 16'(k), 32'h0,
                          p == 0 ? 32'h8F7E_C180 : 32'h7F01_80FF);
                end
            end
        end
        // R6 R7 R8 R9: every store type at every lane
        for (int o = 6; o <= 8; o++) begin
            for (int k = 0; k < 4; k++) begin
                drive(4'(o), 32'h0000_2000, 16'(k), 32'hA1B2_C3D4, 32'h1234_5678);
            end
        end
        // R2: negative displacements and wrap-around
        drive(4'd6, 32'h0000_2000, 16'hFFFE, 32'h0000_00EE, 32'h0);
        drive(4'd3, 32'h0000_0001, 16'hFFFF, 32'h0, 32'hF00D_8001);
        drive(4'd7, 32'hFFFF_FFFF, 16'h0002, 32'h0000_BEEF, 32'h0);
        drive(4'd1, 32'h8000_0000, 16'h8000, 32'h0, 32'h0000_0080);
        // R11: undefined codes and no-op after a load
        drive(4'd2, 32'h0, 16'h3, 32'h0, 32'hAB00_0000);
        for (int o = 9; o <= 15; o++) drive(4'(o), 32'h3000, 16'h1, 32'hFFFF_FFFF, 32'h5555_5555);
        drive(4'd0, 32'h0, 16'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        // mixed random traffic
        for (int i = 0; i < 3000; i++) begin
            drive(4'($urandom_range(0, 15)), $urandom, 16'($urandom), $urandom, $urandom);
        end
        drive(4'd0, 32'h0, 16'h0, 32'h0, 32'h0);
        repeat (4) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule